// File: doc/BRIEF.md
# Dual Complex Add/Accumulate Datapath

This block is a clocked two-lane arithmetic datapath for complex data. One lane carries the real part and the other carries the imaginary part. Each lane registers two signed 16-bit operands and widens them to 20 bits. It then adds, subtracts, reverse-subtracts or passes one operand, and the outcome goes into a 20-bit result register. Both lanes take a new operation on every clock.

A shared feedback select replaces the first operand with the lane's own result register, which makes each lane an accumulator. Each lane has its own operation code, so one device can serve as a conjugator (add on one lane, negate on the other), as one half of a radix-2 butterfly, or as a complex accumulator for filters. A shared synchronous clear zeroes both result registers. A shared delay select feeds the second operand from an 8-stage deskew chain instead of directly from its input register. This keeps samples in phase with data that has gone through a longer external path.

Top module: `cacc_dual`

## Requirements
- R1: A synchronous active-high `rst` clears the input registers, the deskew chains and both result registers, so both results read 0 after the reset edge.
- R2: Each lane applies its own 2-bit operation code, independently of the other lane. The codes are 2'b00 = A+B, 2'b01 = A−B, 2'b10 = B−A and 2'b11 = pass A.
- R3: When `fb_sel` is 1, operand A of both lanes is the lane's own result register and not its input register. Code 2'b00 then accumulates B, and code 2'b11 holds the result unchanged.
- R4: When `clr` is high at a clock edge, both results become 0 on that edge, whatever the operation codes and `fb_sel` are.
- R5: When `dly_en` is 1, operand B of each lane is the value its B input register held 8 clocks earlier. The deskew chain shifts on every clock, whatever the state of `ce`.
- R6: The A and B input registers load only on edges where `ce` is 1. The result registers still update on every edge from the held operands.
- R7: The 16-bit inputs are sign-extended to 20 bits. Sums and differences wrap modulo 2^20.
- R8: Operands presented with `ce` high at edge k affect the result registered at edge k+1. Operation code, `fb_sel`, `clr` and `dly_en` act on the edge where they are sampled. A new result is produced every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce | input | 1 | Load enable for the operand input registers |
| clr | input | 1 | Synchronous clear of both result registers |
| fb_sel | input | 1 | 1: operand A is the lane's result register |
| dly_en | input | 1 | 1: operand B comes from the 8-stage deskew chain |
| op_re | input | 2 | Real lane operation code |
| op_im | input | 2 | Imaginary lane operation code |
| re_a | input | 16 | Real lane operand A, signed |
| re_b | input | 16 | Real lane operand B, signed |
| im_a | input | 16 | Imaginary lane operand A, signed |
| im_b | input | 16 | Imaginary lane operand B, signed |
| res_re | output | 20 | Real lane result register |
| res_im | output | 20 | Imaginary lane result register |

## Verification
The hardest case to reach from the ports is the deskew path while the input load enable is toggling. The chain keeps shifting even when the input registers hold, so the chain fills with repeated copies of the held operand. This is visible only 8 clocks later. The stimulus streams distinct B values with the delay selected, then drops `ce` for several cycles in the middle of the stream, so that the held copies show up in the results. Wrap-around is reached by accumulating a near-maximum positive operand through the feedback path for twenty cycles.

// File: rtl/cacc_pkg.sv
package cacc_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_RSUB = 2'b10,
    OP_PASS = 2'b11
  } cacc_op_e;
endpackage

// File: rtl/cacc_deskew.sv
module cacc_deskew #(
  parameter int unsigned W     = 16,
  parameter int unsigned DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= '0;
        else     stg[i] <= stg[i-1];
      end
    end
  end

  assign dout = stg[DEPTH-1];
endmodule

// File: rtl/cacc_alu.sv
module cacc_alu
  import cacc_pkg::*;
#(
  parameter int unsigned W = 20
) (
  input  logic [1:0]   op,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic [W-1:0] res
);
  always_comb begin
    case (cacc_op_e'(op))
      OP_ADD:  res = opa + opb;
      OP_SUB:  res = opa - opb;
      OP_RSUB: res = opb - opa;
      default: res = opa;
    endcase
  end
endmodule

// File: rtl/cacc_lane.sv
module cacc_lane #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 20,
  parameter int unsigned DLY_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             clr,
  input  logic             fb_sel,
  input  logic             dly_en,
  input  logic [1:0]       op,
  input  logic [IN_W-1:0]  din_a,
  input  logic [IN_W-1:0]  din_b,
  output logic [ACC_W-1:0] acc
);
  localparam int unsigned EXT = ACC_W - IN_W;

  logic [IN_W-1:0]  a_q, b_q, b_dly, b_use;
  logic [ACC_W-1:0] opa, opb, sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (ce) begin
      a_q <= din_a;
      b_q <= din_b;
    end
  end

  cacc_deskew #(.W(IN_W), .DEPTH(DLY_N)) u_dsk (
    .clk  (clk),
    .rst  (rst),
    .din  (b_q),
    .dout (b_dly)
  );

  assign b_use = dly_en ? b_dly : b_q;
  assign opa   = fb_sel ? acc : {{EXT{a_q[IN_W-1]}}, a_q};
  assign opb   = {{EXT{b_use[IN_W-1]}}, b_use};

  cacc_alu #(.W(ACC_W)) u_alu (
    .op  (op),
    .opa (opa),
    .opb (opb),
    .res (sum)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else            acc <= sum;
  end
endmodule

// File: rtl/cacc_dual.sv
module cacc_dual #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 20,
  parameter int unsigned DLY_N = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic             clr,
  input  logic             fb_sel,
  input  logic             dly_en,
  input  logic [1:0]       op_re,
  input  logic [1:0]       op_im,
  input  logic [IN_W-1:0]  re_a,
  input  logic [IN_W-1:0]  re_b,
  input  logic [IN_W-1:0]  im_a,
  input  logic [IN_W-1:0]  im_b,
  output logic [ACC_W-1:0] res_re,
  output logic [ACC_W-1:0] res_im
);
  localparam int unsigned NL = 2;

  logic [NL-1:0][1:0]       op_v;
  logic [NL-1:0][IN_W-1:0]  a_v, b_v;
  logic [NL-1:0][ACC_W-1:0] r_v;

  assign op_v = {op_im, op_re};
  assign a_v  = {im_a, re_a};
  assign b_v  = {im_b, re_b};

  for (genvar g = 0; g < NL; g++) begin : g_lane
    cacc_lane #(.IN_W(IN_W), .ACC_W(ACC_W), .DLY_N(DLY_N)) u_lane (
      .clk    (clk),
      .rst    (rst),
      .ce     (ce),
      .clr    (clr),
      .fb_sel (fb_sel),
      .dly_en (dly_en),
      .op     (op_v[g]),
      .din_a  (a_v[g]),
      .din_b  (b_v[g]),
      .acc    (r_v[g])
    );
  end

  assign res_re = r_v[0];
  assign res_im = r_v[1];
endmodule

// File: rtl/cacc_dual_chk.sv
module cacc_dual_chk #(
  parameter int unsigned ACC_W = 20
) (
  input logic             clk,
  input logic             rst,
  input logic             ce,
  input logic             clr,
  input logic             fb_sel,
  input logic [1:0]       op_re,
  input logic [1:0]       op_im,
  input logic [ACC_W-1:0] res_re,
  input logic [ACC_W-1:0] res_im
);
  logic pass_re;
  assign pass_re = (op_re == 2'b11) && !fb_sel && !clr;

  AST_RST_ZERO: assert property (@(posedge clk)
    rst |=> (res_re == '0) && (res_im == '0)); // R1

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clr |=> (res_re == '0) && (res_im == '0)); // R4

  AST_FB_HOLD_RE: assert property (@(posedge clk) disable iff (rst)
    (fb_sel && !clr && op_re == 2'b11) |=> (res_re == $past(res_re))); // R3

  AST_FB_HOLD_IM: assert property (@(posedge clk) disable iff (rst)
    (fb_sel && !clr && op_im == 2'b11) |=> (res_im == $past(res_im))); // R3

  AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
    ($past(pass_re) && $past(pass_re, 2) && !$past(ce, 2) &&
     !$past(rst) && !$past(rst, 2)) |-> (res_re == $past(res_re))); // R6
endmodule

bind cacc_dual cacc_dual_chk #(.ACC_W(ACC_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .ce     (ce),
  .clr    (clr),
  .fb_sel (fb_sel),
  .op_re  (op_re),
  .op_im  (op_im),
  .res_re (res_re),
  .res_im (res_im)
);

// File: tb/sim_cacc_dual.sv
`timescale 1ns/1ps
module sim_cacc_dual;
  logic        clk = 1'b0;
  logic        rst = 1'b1, ce = 1'b0, clr = 1'b0, fb_sel = 1'b0, dly_en = 1'b0;
  logic [1:0]  op_re = 2'b00, op_im = 2'b00;
  logic [15:0] re_a = '0, re_b = '0, im_a = '0, im_b = '0;
  logic [19:0] res_re, res_im;

  always #2 clk = ~clk;

  cacc_dual u0 (
    .clk(clk), .rst(rst), .ce(ce), .clr(clr), .fb_sel(fb_sel), .dly_en(dly_en),
    .op_re(op_re), .op_im(op_im), .re_a(re_a), .re_b(re_b), .im_a(im_a), .im_b(im_b),
    .res_re(res_re), .res_im(res_im)
  );

  typedef struct {
    logic [19:0] re;
    logic [19:0] im;
    string       tag;
  } exp_t;
  exp_t sb[$];

  int    checks = 0, errors = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  logic [15:0] m_a [2];
  logic [15:0] m_b [2];
  logic [15:0] m_d [2][8];
  logic [19:0] m_acc [2];

  function automatic logic [19:0] sx(input logic [15:0] x);
    return {{4{x[15]}}, x};
  endfunction

  function automatic logic [19:0] f_op(input logic [1:0] op, input logic [19:0] a,
                                       input logic [19:0] b);
    case (op)
      2'b00:   return a + b;
      2'b01:   return a - b;
      2'b10:   return b - a;
      default: return a;
    endcase
  endfunction

  initial begin
    for (int l = 0; l < 2; l++) begin
      m_a[l] = '0; m_b[l] = '0; m_acc[l] = '0;
      for (int s = 0; s < 8; s++) m_d[l][s] = '0;
    end
  end

  task automatic cyc(input logic r, input logic c, input logic cl, input logic fb,
                     input logic dl, input logic [1:0] o_r, input logic [1:0] o_i,
                     input logic [15:0] ra, input logic [15:0] rb,
                     input logic [15:0] ia, input logic [15:0] ib);
    logic [1:0]  opl [2];
    logic [15:0] ina [2];
    logic [15:0] inb [2];
    exp_t e;
    @(negedge clk);
    rst = r; ce = c; clr = cl; fb_sel = fb; dly_en = dl;
    op_re = o_r; op_im = o_i; re_a = ra; re_b = rb; im_a = ia; im_b = ib;
    opl[0] = o_r; opl[1] = o_i; ina[0] = ra; ina[1] = ia; inb[0] = rb; inb[1] = ib;
    @(posedge clk);
    #1;
    for (int l = 0; l < 2; l++) begin
      logic [19:0] av, bv;
      av = fb ? m_acc[l] : sx(m_a[l]);
      bv = sx(dl ? m_d[l][7] : m_b[l]);
      m_acc[l] = (r || cl) ? 20'd0 : f_op(opl[l], av, bv);
      for (int s = 7; s > 0; s--) m_d[l][s] = r ? 16'd0 : m_d[l][s-1];
      m_d[l][0] = r ? 16'd0 : m_b[l];
      if (r) begin
        m_a[l] = '0; m_b[l] = '0;
      end else if (c) begin
        m_a[l] = ina[l]; m_b[l] = inb[l];
      end
    end
    e.re = m_acc[0]; e.im = m_acc[1]; e.tag = cur_tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (res_re !== e.re || res_im !== e.im) begin
        errors++;
        $display("FAIL %s: res_re=%h res_im=%h expected re=%h im=%h",
                 e.tag, res_re, res_im, e.re, e.im);
      end
    end
  end

  initial begin
    // R1: reset state
    cur_tag = "R1";
    repeat (3) cyc(1, 0, 0, 0, 0, 2'b00, 2'b00, 16'h1234, 16'h5678, 16'h9abc, 16'hdef0);

    // R2 R7 R8: independent op codes per lane with signed and extreme data
    cur_tag = "R2/R7/R8";
    for (int i = 0; i < 16; i++) begin
      cyc(0, 1, 0, 0, 0, i[1:0], i[3:2],
          16'(i * 1234 - 9000), 16'(7000 - i * 811),
          16'(i * 333 + 50), 16'(-i * 2900));
    end
    cur_tag = "R7";
    cyc(0, 1, 0, 0, 0, 2'b01, 2'b10, 16'h8000, 16'h7fff, 16'h8000, 16'h7fff);
    cyc(0, 1, 0, 0, 0, 2'b00, 2'b01, 16'h8000, 16'h8000, 16'h7fff, 16'h8000);
    cyc(0, 1, 0, 0, 0, 2'b11, 2'b11, 16'hffff, 16'h0001, 16'h0000, 16'h0000);

    // R3 R7: accumulate with feedback until the 20-bit result wraps
    cur_tag = "R3/R7";
    cyc(0, 1, 1, 0, 0, 2'b00, 2'b00, 16'h0000, 16'h7fff, 16'h0000, 16'h8001);
    for (int i = 0; i < 20; i++)
      cyc(0, 1, 0, 1, 0, 2'b00, 2'b01, 16'h0000, 16'h7fff, 16'h0000, 16'h8001);
    cur_tag = "R3";
    repeat (3) cyc(0, 1, 0, 1, 0, 2'b11, 2'b11, 16'h1111, 16'h2222, 16'h3333, 16'h4444);

    // R4: clear overrides accumulation on both lanes
    cur_tag = "R4";
    cyc(0, 1, 1, 1, 0, 2'b00, 2'b01, 16'h0100, 16'h0200, 16'h0300, 16'h0400);
    cyc(0, 1, 0, 1, 0, 2'b00, 2'b00, 16'h0100, 16'h0200, 16'h0300, 16'h0400);
    cyc(0, 1, 1, 0, 0, 2'b11, 2'b10, 16'h0100, 16'h0200, 16'h0300, 16'h0400);

    // R6: input registers hold while ce is low, results still update
    cur_tag = "R6";
    cyc(0, 1, 0, 0, 0, 2'b11, 2'b00, 16'd100, 16'd7, 16'd200, 16'd9);
    for (int i = 0; i < 4; i++)
      cyc(0, 0, 0, 0, 0, 2'b11, 2'b00, 16'(555 + i), 16'(99 + i), 16'(777 + i), 16'(88 + i));
    cyc(0, 0, 0, 1, 0, 2'b00, 2'b00, 16'd1, 16'd1, 16'd1, 16'd1);

    // R5: deskew path, with ce dropped in the middle of the stream
    cur_tag = "R5";
    for (int i = 0; i < 14; i++)
      cyc(0, 1, 0, 0, 1, 2'b00, 2'b01, 16'h0000, 16'(i * 37 - 300), 16'h0000, 16'(i * 515 + 3));
    for (int i = 0; i < 3; i++)
      cyc(0, 0, 0, 0, 1, 2'b00, 2'b01, 16'h0000, 16'h7777, 16'h0000, 16'h6666);
    for (int i = 0; i < 12; i++)
      cyc(0, 1, 0, 0, (i % 5) != 4, 2'b00, 2'b00, 16'(i), 16'(-i * 101), 16'(2 * i), 16'(i * 61));

    // R1: reset after nonzero state
    cur_tag = "R1";
    cyc(0, 1, 0, 0, 0, 2'b00, 2'b00, 16'd500, 16'd600, 16'd700, 16'd800);
    cyc(1, 1, 0, 0, 0, 2'b00, 2'b00, 16'd500, 16'd600, 16'd700, 16'd800);
    cyc(0, 0, 0, 0, 1, 2'b00, 2'b00, 16'd500, 16'd600, 16'd700, 16'd800);

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule